// File: doc/BRIEF.md
# Debug port mode selector

This block sits on the target side of a two-wire debug link and decides which protocol the port currently speaks: JTAG, SWD or dormant. It samples the data/mode line on every rising edge of the debug clock. It tracks runs of high bits and keeps a shift history of the most recently received bits. From these it recognises the 16-bit switch codes, the 31-bit JTAG-to-dormant code, the 128-bit wake-up alert and the activation codes that follow it. Every code is received least-significant bit first.

The selected protocol is presented as a registered two-bit mode. Downstream logic (the TAP controller, the SWD packet engine) uses it to decide which of them owns the line. A one-cycle line-reset pulse tells the SWD engine that a reset just completed. A one-cycle protocol-error pulse reports an activation attempt that named no known protocol.

Top module: `dbg_mode_sel`

## Requirements
- R1: After reset the mode output reads JTAG and both pulse outputs are low. Mode encoding: 2'b00 JTAG, 2'b01 SWD, 2'b10 dormant. The value 2'b11 never appears.
- R2: In JTAG mode, a run of at least 50 high bits followed by the 16-bit value 0xE79E (LSB-first) selects SWD. Runs longer than 50 are accepted. The mode changes on the clock edge that samples the last code bit. A run of 49 high bits does not qualify.
- R3: In SWD mode, at least 50 high bits followed by 0xE73C (LSB-first) selects JTAG on the edge of the last code bit.
- R4: In SWD mode, at least 50 high bits followed by 0xE3BC (LSB-first) selects dormant on the edge of the last code bit.
- R5: In JTAG mode, at least 5 high bits followed by the 31-bit value 0x33BBBBBA (LSB-first) selects dormant. A run of only 4 high bits does not qualify.
- R6: In dormant mode, the wake-up alert is accepted only after at least 8 high bits. The alert is the 128-bit value 0x19BC0EA2_E3DDAFE9_86852D95_6209F392 sent LSB-first. With a shorter run, or with any alert bit wrong, the block stays dormant and ignores the bits that follow.
- R7: After an accepted alert, 4 low bits followed by the 8-bit activation code 0x1A (LSB-first) select SWD on the edge of the last code bit.
- R8: After an accepted alert, 4 low bits followed by 12 low bits select JTAG on the edge of the 16th low bit.
- R9: After an accepted alert, a high bit among the 4 gap bits, an 8-bit code that is neither 0x1A nor 0x00, or a high bit among the last 4 of the JTAG code raises a one-cycle protocol-error pulse. The block stays dormant and waits for a new alert.
- R10: In SWD mode, at least 50 high bits followed by two low bits raise a one-cycle line-reset pulse on the edge of the second low bit. A 49-bit run raises none.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Debug clock; the data line is sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dio_i | input | 1 | Data/mode line value |
| mode_o | output | 2 | Selected protocol: 00 JTAG, 01 SWD, 10 dormant |
| line_reset_o | output | 1 | One-cycle pulse when an SWD line reset completes |
| proto_err_o | output | 1 | One-cycle pulse when an activation attempt fails |

## Verification
Line-reset detection and switch-code capture both start on the first low bit after a long high run. The SWD-to-dormant code begins with two low bits, so in SWD mode the line-reset pulse fires on the second code bit while the 16-bit capture is still running. The bench sends 50 high bits and that code from SWD mode. It expects the pulse after code bit 1 with the mode still SWD, the mode still SWD after bit 14, and dormant after bit 15. This shows that the shared detection neither swallows the pulse nor disturbs the capture. The checker also requires every line-reset pulse to be issued while the mode is SWD.

// File: rtl/dpsel_pkg.sv
package dpsel_pkg;

  typedef enum logic [1:0] {
    MODE_JTAG = 2'b00,
    MODE_SWD  = 2'b01,
    MODE_DORM = 2'b10
  } mode_e;

  typedef enum logic [1:0] {
    ST_JTAG,
    ST_SWD,
    ST_DORM,
    ST_WAKE
  } sel_state_e;

  // protocol constants, first-received bit at bit 0
  localparam logic [15:0]  SW_J2S    = 16'hE79E;
  localparam logic [15:0]  SW_S2J    = 16'hE73C;
  localparam logic [15:0]  SW_S2D    = 16'hE3BC;
  localparam logic [30:0]  SW_J2D    = 31'h33BBBBBA;
  localparam logic [127:0] WAKE_SEQ  = 128'h19BC0EA2_E3DDAFE9_86852D95_6209F392;
  localparam logic [7:0]   ACT_SWD   = 8'h1A;
  localparam int           JTAG_ACT_BITS = 12;
  localparam int           ACT_GAP_BITS  = 4;

  function automatic mode_e mode_of(sel_state_e st);
    case (st)
      ST_JTAG: mode_of = MODE_JTAG;
      ST_SWD:  mode_of = MODE_SWD;
      default: mode_of = MODE_DORM;
    endcase
  endfunction

endpackage

// File: rtl/dpsel_rst_sync.sv
module dpsel_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/dpsel_run_cnt.sv
// Counts consecutive high samples, saturating at the long-run threshold,
// and flags the low sample that closes a qualifying run.
module dpsel_run_cnt #(
  parameter int LONG_MIN = 50,
  localparam int RW = $clog2(LONG_MIN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dio_i,
  input  logic [RW-1:0] short_thr_i,
  output logic          long_arm_o,
  output logic          short_arm_o
);
  localparam logic [RW-1:0] LONG_LIM = RW'(LONG_MIN);

  logic [RW-1:0] run_q, run_n;

  always_comb begin
    if (!dio_i)               run_n = '0;
    else if (run_q == LONG_LIM) run_n = run_q;
    else                      run_n = run_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else         run_q <= run_n;
  end

  assign long_arm_o  = !dio_i && (run_q >= LONG_LIM);
  assign short_arm_o = !dio_i && (run_q >= short_thr_i);
endmodule

// File: rtl/dpsel_win_cnt.sv
// Position counter for a code window opened by an arming sample.
// done_o marks the sample that completes a window of limit_i bits.
module dpsel_win_cnt #(
  parameter int MAX_W = 128,
  localparam int CW = $clog2(MAX_W + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic          clr_i,
  input  logic [CW-1:0] limit_i,
  output logic          done_o
);
  logic [CW-1:0] pos_q, pos_n;

  assign done_o = (pos_q != '0) && (pos_q == limit_i - 1'b1);

  always_comb begin
    if (clr_i)             pos_n = '0;
    else if (arm_i)        pos_n = CW'(1);
    else if (done_o)       pos_n = '0;
    else if (pos_q != '0)  pos_n = pos_q + 1'b1;
    else                   pos_n = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pos_q <= '0;
    else         pos_q <= pos_n;
  end
endmodule

// File: rtl/dpsel_pattern.sv
// Shift history of received bits; newest bit enters at the top so an
// LSB-first word of N bits sits in the top N positions.
module dpsel_pattern
  import dpsel_pkg::*;
#(
  parameter int HIST_W = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dio_i,
  output logic hit_j2s_o,
  output logic hit_s2j_o,
  output logic hit_s2d_o,
  output logic hit_j2d_o,
  output logic hit_wake_o,
  output logic hit_act_swd_o,
  output logic hit_act_zero_o
);
  localparam int SWW  = $bits(SW_J2S);
  localparam int J2DW = $bits(SW_J2D);
  localparam int WKW  = $bits(WAKE_SEQ);
  localparam int ACW  = $bits(ACT_SWD);

  logic [HIST_W-2:0] hist_q;
  logic [HIST_W-1:0] hist_n;

  assign hist_n = {dio_i, hist_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else         hist_q <= hist_n[HIST_W-1:1];
  end

  assign hit_j2s_o      = hist_n[HIST_W-1 -: SWW]  == SW_J2S;
  assign hit_s2j_o      = hist_n[HIST_W-1 -: SWW]  == SW_S2J;
  assign hit_s2d_o      = hist_n[HIST_W-1 -: SWW]  == SW_S2D;
  assign hit_j2d_o      = hist_n[HIST_W-1 -: J2DW] == SW_J2D;
  assign hit_wake_o     = hist_n[HIST_W-1 -: WKW]  == WAKE_SEQ;
  assign hit_act_swd_o  = hist_n[HIST_W-1 -: ACW]  == ACT_SWD;
  assign hit_act_zero_o = hist_n[HIST_W-1 -: ACW]  == '0;
endmodule

// File: rtl/dpsel_fsm.sv
module dpsel_fsm
  import dpsel_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dio_i,
  input  logic long_arm_i,
  input  logic long_done_i,
  input  logic short_done_i,
  input  logic hit_j2s_i,
  input  logic hit_s2j_i,
  input  logic hit_s2d_i,
  input  logic hit_j2d_i,
  input  logic hit_wake_i,
  input  logic hit_act_swd_i,
  input  logic hit_act_zero_i,
  output logic clr_o,
  output logic dorm_o,
  output logic [1:0] mode_o,
  output logic line_reset_o,
  output logic proto_err_o
);
  localparam int ACT_LEN = ACT_GAP_BITS + JTAG_ACT_BITS;
  localparam int AW      = $clog2(ACT_LEN);
  localparam logic [AW-1:0] GAP_END  = AW'(ACT_GAP_BITS);
  localparam logic [AW-1:0] SWD_END  = AW'(ACT_GAP_BITS + $bits(ACT_SWD) - 1);
  localparam logic [AW-1:0] JTAG_END = AW'(ACT_LEN - 1);

  sel_state_e    state_q, state_n;
  logic [AW-1:0] act_q, act_n;
  logic          lr_pend_q, lr_pend_n;
  logic          lr_q, lr_n;
  logic          err_q, err_n;
  mode_e         mode_q;

  always_comb begin
    state_n = state_q;
    act_n   = act_q;
    err_n   = 1'b0;
    case (state_q)
      ST_JTAG: begin
        if (long_done_i && hit_j2s_i)       state_n = ST_SWD;
        else if (short_done_i && hit_j2d_i) state_n = ST_DORM;
      end
      ST_SWD: begin
        if (long_done_i && hit_s2j_i)       state_n = ST_JTAG;
        else if (long_done_i && hit_s2d_i)  state_n = ST_DORM;
      end
      ST_DORM: begin
        if (short_done_i && hit_wake_i) begin
          state_n = ST_WAKE;
          act_n   = '0;
        end
      end
      default: begin
        act_n = act_q + 1'b1;
        if ((act_q < GAP_END || act_q > SWD_END) && dio_i) begin
          state_n = ST_DORM;
          err_n   = 1'b1;
        end else if (act_q == SWD_END) begin
          if (hit_act_swd_i) state_n = ST_SWD;
          else if (!hit_act_zero_i) begin
            state_n = ST_DORM;
            err_n   = 1'b1;
          end
        end else if (act_q == JTAG_END) begin
          state_n = ST_JTAG;
        end
      end
    endcase
  end

  // line reset: long run closed by a low, then a second low
  always_comb begin
    lr_n      = 1'b0;
    lr_pend_n = 1'b0;
    if (state_q == ST_SWD) begin
      lr_n      = lr_pend_q && !dio_i;
      lr_pend_n = long_arm_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_JTAG;
      act_q     <= '0;
      lr_pend_q <= 1'b0;
      lr_q      <= 1'b0;
      err_q     <= 1'b0;
      mode_q    <= MODE_JTAG;
    end else begin
      state_q   <= state_n;
      act_q     <= act_n;
      lr_pend_q <= lr_pend_n;
      lr_q      <= lr_n;
      err_q     <= err_n;
      mode_q    <= mode_of(state_n);
    end
  end

  assign clr_o        = state_n != state_q;
  assign dorm_o       = state_q == ST_DORM;
  assign mode_o       = mode_q;
  assign line_reset_o = lr_q;
  assign proto_err_o  = err_q;
endmodule

// File: rtl/dbg_mode_sel.sv
module dbg_mode_sel
  import dpsel_pkg::*;
#(
  parameter int LONG_MIN  = 50,
  parameter int TLR_MIN   = 5,
  parameter int WAKE_MIN  = 8,
  parameter int SYNC_STG  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dio_i,
  output logic [1:0] mode_o,
  output logic       line_reset_o,
  output logic       proto_err_o
);
  localparam int RW   = $clog2(LONG_MIN + 1);
  localparam int SWW  = $bits(SW_J2S);
  localparam int J2DW = $bits(SW_J2D);
  localparam int WKW  = $bits(WAKE_SEQ);
  localparam int LCW  = $clog2(SWW + 1);
  localparam int SCW  = $clog2(WKW + 1);

  logic          rst_n;
  logic          long_arm, short_arm, long_done, short_done;
  logic          clr, dorm;
  logic [RW-1:0] short_thr;
  logic [SCW-1:0] short_lim;
  logic hit_j2s, hit_s2j, hit_s2d, hit_j2d, hit_wake, hit_swd, hit_zero;

  dpsel_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk_i (clk_i), .rst_ni (rst_ni), .rst_no (rst_n)
  );

  assign short_thr = dorm ? RW'(WAKE_MIN) : RW'(TLR_MIN);
  assign short_lim = dorm ? SCW'(WKW) : SCW'(J2DW);

  dpsel_run_cnt #(.LONG_MIN(LONG_MIN)) u_run (
    .clk_i (clk_i), .rst_ni (rst_n), .dio_i (dio_i),
    .short_thr_i (short_thr),
    .long_arm_o (long_arm), .short_arm_o (short_arm)
  );

  dpsel_win_cnt #(.MAX_W(SWW)) u_win_long (
    .clk_i (clk_i), .rst_ni (rst_n), .arm_i (long_arm), .clr_i (clr),
    .limit_i (LCW'(SWW)), .done_o (long_done)
  );

  dpsel_win_cnt #(.MAX_W(WKW)) u_win_short (
    .clk_i (clk_i), .rst_ni (rst_n), .arm_i (short_arm), .clr_i (clr),
    .limit_i (short_lim), .done_o (short_done)
  );

  dpsel_pattern #(.HIST_W(WKW)) u_pat (
    .clk_i (clk_i), .rst_ni (rst_n), .dio_i (dio_i),
    .hit_j2s_o (hit_j2s), .hit_s2j_o (hit_s2j), .hit_s2d_o (hit_s2d),
    .hit_j2d_o (hit_j2d), .hit_wake_o (hit_wake),
    .hit_act_swd_o (hit_swd), .hit_act_zero_o (hit_zero)
  );

  dpsel_fsm u_fsm (
    .clk_i (clk_i), .rst_ni (rst_n), .dio_i (dio_i),
    .long_arm_i (long_arm), .long_done_i (long_done), .short_done_i (short_done),
    .hit_j2s_i (hit_j2s), .hit_s2j_i (hit_s2j), .hit_s2d_i (hit_s2d),
    .hit_j2d_i (hit_j2d), .hit_wake_i (hit_wake),
    .hit_act_swd_i (hit_swd), .hit_act_zero_i (hit_zero),
    .clr_o (clr), .dorm_o (dorm), .mode_o (mode_o),
    .line_reset_o (line_reset_o), .proto_err_o (proto_err_o)
  );
endmodule

// File: rtl/dpsel_chk.sv
module dpsel_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       dio_i,
  input logic [1:0] mode_o,
  input logic       line_reset_o,
  input logic       proto_err_o
);
  // R1
  mode_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'b11);

  // R10
  lr_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_reset_o |=> !line_reset_o);

  // R10
  lr_in_swd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_reset_o |-> ($past(mode_o) == 2'b01));

  // R9
  err_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |=> !proto_err_o);

  // R9
  err_dormant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |-> (mode_o == 2'b10 && $stable(mode_o)));

  // R2
  j2s_last_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_o) == 2'b00 && mode_o == 2'b01) |-> $past(dio_i));

  // R4
  s2d_last_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_o) == 2'b01 && mode_o == 2'b10) |-> $past(dio_i));

  // R8
  wake_jtag_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_o) == 2'b10 && mode_o == 2'b00) |-> !$past(dio_i));
endmodule

bind dbg_mode_sel dpsel_chk u_chk (
  .clk_i (clk_i), .rst_ni (rst_ni), .dio_i (dio_i),
  .mode_o (mode_o), .line_reset_o (line_reset_o), .proto_err_o (proto_err_o)
);

// File: tb/dbg_mode_sel_tb.sv
`timescale 1ns/1ps
module dbg_mode_sel_tb;
  localparam logic [1:0] M_JTAG = 2'b00;
  localparam logic [1:0] M_SWD  = 2'b01;
  localparam logic [1:0] M_DORM = 2'b10;
  localparam logic [127:0] WAKE = 128'h19BC0EA2_E3DDAFE9_86852D95_6209F392;

  logic       clk;
  logic       rst_n;
  logic       dio;
  logic [1:0] mode;
  logic       lr;
  logic       perr;
  int         checks;
  int         errors;
  bit         done;

  dbg_mode_sel u_dut (
    .clk_i (clk), .rst_ni (rst_n), .dio_i (dio),
    .mode_o (mode), .line_reset_o (lr), .proto_err_o (perr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    dio = b;
    @(posedge clk);
    #1;
  endtask

  task automatic send_run(input logic b, input int n);
    for (int i = 0; i < n; i++) send_bit(b);
  endtask

  task automatic send_range(input logic [127:0] w, input int lo, input int hi);
    for (int i = lo; i <= hi; i++) send_bit(w[i]);
  endtask

  task automatic wake_then(input logic [127:0] alert, input int lead);
    send_run(1'b0, 2);
    send_run(1'b1, lead);
    send_range(alert, 0, 127);
  endtask

  task automatic t_reset;
    chk("R1 mode", mode, M_JTAG);
    chk("R1 line_reset", lr, 0);
    chk("R1 proto_err", perr, 0);
  endtask

  task automatic t_jtag_to_swd;
    send_run(1'b0, 2);
    send_run(1'b1, 49);
    send_range(128'hE79E, 0, 15);
    chk("R2 49-bit run rejected", mode, M_JTAG);
    send_run(1'b0, 2);
    send_run(1'b1, 57);
    send_range(128'hE79E, 0, 14);
    chk("R2 before last bit", mode, M_JTAG);
    send_range(128'hE79E, 15, 15);
    chk("R2 after last bit", mode, M_SWD);
  endtask

  task automatic t_line_reset;
    send_run(1'b0, 2);
    send_run(1'b1, 49);
    send_run(1'b0, 2);
    chk("R10 49-bit run no pulse", lr, 0);
    send_run(1'b1, 50);
    send_bit(1'b0);
    chk("R10 first low no pulse", lr, 0);
    send_bit(1'b0);
    chk("R10 pulse on second low", lr, 1);
    send_bit(1'b0);
    chk("R10 pulse one cycle", lr, 0);
    chk("R10 mode kept", mode, M_SWD);
  endtask

  task automatic t_swd_to_jtag;
    send_run(1'b0, 2);
    send_run(1'b1, 50);
    send_range(128'hE73C, 0, 14);
    chk("R3 before last bit", mode, M_SWD);
    send_range(128'hE73C, 15, 15);
    chk("R3 after last bit", mode, M_JTAG);
  endtask

  task automatic t_jtag_to_dormant;
    send_run(1'b0, 3);
    send_run(1'b1, 4);
    send_range(128'h33BBBBBA, 0, 30);
    chk("R5 4-bit run rejected", mode, M_JTAG);
    send_run(1'b0, 3);
    send_run(1'b1, 5);
    send_range(128'h33BBBBBA, 0, 29);
    chk("R5 before last bit", mode, M_JTAG);
    send_range(128'h33BBBBBA, 30, 30);
    chk("R5 after last bit", mode, M_DORM);
  endtask

  task automatic t_wake_swd;
    logic [127:0] bad;
    bad = WAKE;
    bad[8] = 1'b0;
    wake_then(WAKE, 7);
    send_run(1'b0, 4);
    send_range(128'h1A, 0, 7);
    chk("R6 7-bit lead ignored", mode, M_DORM);
    chk("R6 7-bit lead no error", perr, 0);
    wake_then(bad, 8);
    send_run(1'b0, 4);
    send_range(128'h1A, 0, 7);
    chk("R6 broken alert ignored", mode, M_DORM);
    wake_then(WAKE, 8);
    send_run(1'b0, 4);
    send_range(128'h1A, 0, 6);
    chk("R7 before last code bit", mode, M_DORM);
    send_range(128'h1A, 7, 7);
    chk("R7 after last code bit", mode, M_SWD);
  endtask

  task automatic t_swd_to_dormant_overlap;
    send_run(1'b0, 2);
    send_run(1'b1, 50);
    send_range(128'hE3BC, 0, 0);
    chk("R10 no pulse on code bit 0", lr, 0);
    send_range(128'hE3BC, 1, 1);
    chk("R10 pulse on code bit 1", lr, 1);
    chk("R4 still SWD at bit 1", mode, M_SWD);
    send_range(128'hE3BC, 2, 14);
    chk("R4 before last bit", mode, M_SWD);
    send_range(128'hE3BC, 15, 15);
    chk("R4 after last bit", mode, M_DORM);
  endtask

  task automatic t_wake_jtag;
    wake_then(WAKE, 8);
    send_run(1'b0, 12);
    chk("R8 after 12 lows", mode, M_DORM);
    chk("R8 no error on zero code", perr, 0);
    send_run(1'b0, 3);
    chk("R8 before last low", mode, M_DORM);
    send_bit(1'b0);
    chk("R8 after 16th low", mode, M_JTAG);
  endtask

  task automatic t_bad_activation;
    send_run(1'b0, 3);
    send_run(1'b1, 6);
    send_range(128'h33BBBBBA, 0, 30);
    chk("R9 setup dormant", mode, M_DORM);
    wake_then(WAKE, 8);
    send_run(1'b0, 4);
    send_range(128'h5A, 0, 6);
    chk("R9 no error before code end", perr, 0);
    send_range(128'h5A, 7, 7);
    chk("R9 error on bad code", perr, 1);
    chk("R9 stays dormant", mode, M_DORM);
    send_bit(1'b0);
    chk("R9 error one cycle", perr, 0);
    wake_then(WAKE, 9);
    send_bit(1'b0);
    send_bit(1'b1);
    chk("R9 error on high gap bit", perr, 1);
    chk("R9 gap error dormant", mode, M_DORM);
    wake_then(WAKE, 8);
    send_run(1'b0, 4);
    send_range(128'h1A, 0, 7);
    chk("R9 recovery to SWD", mode, M_SWD);
  endtask

  task automatic finish_up;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual 0 expected 1");
      finish_up();
    end
  end

  initial begin
    checks = 0;
    errors = 0;
    done   = 1'b0;
    dio    = 1'b0;
    rst_n  = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    t_jtag_to_swd();
    t_line_reset();
    t_swd_to_jtag();
    t_jtag_to_dormant();
    t_wake_swd();
    t_swd_to_dormant_overlap();
    t_wake_jtag();
    t_bad_activation();
    done = 1'b1;
    finish_up();
  end
endmodule